// File: doc/BRIEF.md
# Seconds and Nanoseconds Time Counter

This block keeps a free-running time of day as a 64-bit whole-seconds count and a 32-bit nanoseconds count. The nanoseconds part always stays below one billion. On every clock cycle a programmable step, in nanoseconds, is added to it. When the sum reaches one billion, the excess stays in the nanoseconds field and the seconds count goes up by one in the same cycle. The step is the clock period expressed in nanoseconds, so a 100 MHz clock uses a step of 10.

Software uses a word-wide register port with a one-cycle read latency. Reading the low seconds word returns the live value and, on the same edge, freezes a copy of the high seconds word and of the nanoseconds. Reads of those two words that follow therefore belong to the same instant, however much time passes in between. To set the time, software writes the new seconds and nanoseconds into holding registers and then writes the commit address. The commit moves the whole value into the counter in a single cycle. A nanoseconds value that is out of range is limited to the last nanosecond of the second.

Top module: `tod_counter`

## Requirements
- R1: While reset is high and after it falls, seconds and nanoseconds are zero, the step equals parameter DEFAULT_STEP, `rdata` is 0 and `rd_valid` is low.
- R2: When no commit takes place and nanoseconds plus step is below 1,000,000,000, each clock adds the step to the nanoseconds and leaves the seconds unchanged.
- R3: When nanoseconds plus step is 1,000,000,000 or more, the same clock sets the nanoseconds to that sum minus 1,000,000,000 and adds one to the seconds. The nanoseconds never reach 1,000,000,000.
- R4: The seconds count is 64 bits wide. An increment from 0x0000_0000_FFFF_FFFF gives 0x0000_0001_0000_0000.
- R5: A read of address 0 returns seconds[31:0] as it was at the read edge. On that edge it also stores seconds[63:32] and the nanoseconds. Reads of address 1 (seconds[63:32]) and address 2 (nanoseconds) return these stored values until the next read of address 0.
- R6: Writes to address 4 (seconds[31:0]), 5 (seconds[63:32]) and 6 (nanoseconds) only fill holding registers. They leave the running time unchanged.
- R7: Any write to address 7 loads all held seconds and nanoseconds into the counter on that edge. Counting by the step resumes on the next edge.
- R8: A held nanoseconds value of 1,000,000,000 or more is loaded as 999,999,999.
- R9: Address 3 holds the step and can be read and written. A written value above 999,999,999 is stored as 999,999,999. Reads of addresses 4 to 7 return 0.
- R10: `rd_valid` goes high in the cycle after the cycle in which `rd_en` was sampled, and only then. `rdata` holds the answer while `rd_valid` is high, including for reads issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid together with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The counter is run with several steps, and each step separates a different possible fault:
- Steps of 10 and 7 check plain accumulation.
- A step of 1 next to 999,999,999 checks the exact rollover boundary: greater-or-equal against strictly-greater, and the remainder that is kept.
- A step of 333,333,333 produces frequent carries with non-zero remainders.
- A step of zero freezes time. This shows that staging writes and clamped loads have no side effect.

Loads just below 2^32 seconds separate a true 64-bit carry from a 32-bit one. Reads of the frozen words taken many cycles after address 0 separate a snapshot from live data.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int DATA_W    = 32;
    localparam int NS_W      = 32;
    localparam int SEC_W     = 64;
    localparam int ADDR_W    = 3;
    localparam int SEC_WORDS = SEC_W / DATA_W;

    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);
    localparam logic [NS_W-1:0] NS_MAX     = NS_PER_SEC - 1'b1;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC_LO    = 3'd0,
        A_SEC_HI    = 3'd1,
        A_NSEC      = 3'd2,
        A_STEP      = 3'd3,
        A_LD_SEC_LO = 3'd4,
        A_LD_SEC_HI = 3'd5,
        A_LD_NSEC   = 3'd6,
        A_COMMIT    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    // Limit a nanosecond quantity to the last nanosecond of a second.
    function automatic logic [NS_W-1:0] ns_limit(input logic [NS_W-1:0] v);
        return (v >= NS_PER_SEC) ? NS_MAX : v;
    endfunction

    // One tick of the counter: add the step, carry into seconds on overflow.
    function automatic tod_t tod_advance(input tod_t t, input logic [NS_W-1:0] step);
        tod_t          n;
        logic [NS_W:0] sum;
        sum = {1'b0, t.ns} + {1'b0, step};
        n   = t;
        if (sum >= {1'b0, NS_PER_SEC}) begin
            n.ns  = NS_W'(sum - {1'b0, NS_PER_SEC});
            n.sec = t.sec + 1'b1;
        end else begin
            n.ns  = sum[NS_W-1:0];
        end
        return n;
    endfunction

endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
    import tod_pkg::*;
#(
    parameter logic [NS_W-1:0] DEFAULT_STEP = NS_W'(10)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NS_W-1:0]   step,
    output tod_t              staged,
    output logic              commit
);

    logic [DATA_W-1:0] sec_word [SEC_WORDS];
    logic [NS_W-1:0]   stage_ns;
    logic [NS_W-1:0]   step_q;

    // Holding registers for the seconds, one per data word.
    for (genvar w = 0; w < SEC_WORDS; w++) begin : g_sec_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(int'(A_LD_SEC_LO) + w);
        always_ff @(posedge clk) begin
            if (rst) begin
                sec_word[w] <= '0;
            end else if (wr_en && addr == WADDR) begin
                sec_word[w] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_ns <= '0;
            step_q   <= ns_limit(DEFAULT_STEP);
        end else if (wr_en) begin
            if (addr == A_LD_NSEC) stage_ns <= NS_W'(wdata);
            if (addr == A_STEP)    step_q   <= ns_limit(NS_W'(wdata));
        end
    end

    always_comb begin
        for (int w = 0; w < SEC_WORDS; w++) begin
            staged.sec[w*DATA_W +: DATA_W] = sec_word[w];
        end
        staged.ns = stage_ns;
    end

    assign step   = step_q;
    assign commit = wr_en && (addr == A_COMMIT);

endmodule

// File: rtl/tod_core.sv
module tod_core
    import tod_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NS_W-1:0] step,
    input  logic            commit,
    input  tod_t            staged,
    output tod_t            cur
);

    tod_t time_q;
    tod_t time_d;

    always_comb begin
        if (commit) begin
            time_d.sec = staged.sec;
            time_d.ns  = ns_limit(staged.ns);
        end else begin
            time_d = tod_advance(time_q, step);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) time_q <= '0;
        else     time_q <= time_d;
    end

    assign cur = time_q;

endmodule

// File: rtl/tod_readport.sv
module tod_readport
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  tod_t              cur,
    input  logic [NS_W-1:0]   step,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output tod_t              snap
);

    tod_t              snap_q;
    logic [DATA_W-1:0] rsel;
    logic [DATA_W-1:0] rdata_q;
    logic              valid_q;

    always_comb begin
        unique case (addr)
            A_SEC_LO: rsel = cur.sec[0 +: DATA_W];
            A_SEC_HI: rsel = snap_q.sec[DATA_W +: DATA_W];
            A_NSEC:   rsel = DATA_W'(snap_q.ns);
            A_STEP:   rsel = DATA_W'(step);
            default:  rsel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            rdata_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) rdata_q <= rsel;
            if (rd_en && addr == A_SEC_LO) snap_q <= cur;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = valid_q;
    assign snap     = snap_q;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter logic [NS_W-1:0] DEFAULT_STEP = NS_W'(10)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);

    logic [NS_W-1:0] step;
    logic            commit;
    tod_t            staged;
    tod_t            cur_time;
    tod_t            snap;

    tod_regfile #(.DEFAULT_STEP(DEFAULT_STEP)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .step   (step),
        .staged (staged),
        .commit (commit)
    );

    tod_core u_core (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .commit (commit),
        .staged (staged),
        .cur    (cur_time)
    );

    tod_readport u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .cur      (cur_time),
        .step     (step),
        .rdata    (rdata),
        .rd_valid (rd_valid),
        .snap     (snap)
    );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input tod_t              cur,
    input logic [NS_W-1:0]   step,
    input logic              commit,
    input tod_t              staged,
    input tod_t              snap
);

    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur.ns < NS_PER_SEC);

    // R2
    ns_accum_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && (33'(cur.ns) + 33'(step)) < 33'(NS_PER_SEC))
        |=> (cur.ns == $past(cur.ns) + $past(step)) && $stable(cur.sec));

    // R3
    sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && (33'(cur.ns) + 33'(step)) >= 33'(NS_PER_SEC))
        |=> cur.sec == $past(cur.sec) + 1'b1);

    // R7
    commit_load_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> cur.sec == $past(staged.sec));

    // R8
    ns_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && staged.ns >= NS_PER_SEC) |=> cur.ns == NS_MAX);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == A_SEC_LO) |=> $stable(snap));

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .rd_valid (rd_valid),
    .cur      (cur_time),
    .step     (step),
    .commit   (commit),
    .staged   (staged),
    .snap     (snap)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
    import tod_pkg::*;

    localparam logic [31:0] BILLION = 32'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;

    always #5 clk = ~clk;

    tod_counter #(.DEFAULT_STEP(32'd10)) i_tod_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
    );

    int    n_vec = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string cur_tag = "R1";

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements; the expected read data are
    // queued on the edge that samples each read.
    logic [63:0] m_sec, m_ssec, m_snap_sec;
    logic [31:0] m_ns, m_sns, m_snap_ns, m_step;

    always @(posedge clk) begin
        longint t;
        logic [31:0] e;
        if (rst) begin
            m_sec = '0; m_ns = '0; m_ssec = '0; m_sns = '0;
            m_snap_sec = '0; m_snap_ns = '0; m_step = 32'd10;
        end else begin
            if (rd_en) begin
                case (addr)
                    3'd0: begin
                        e = m_sec[31:0];
                        m_snap_sec = m_sec;
                        m_snap_ns  = m_ns;
                    end
                    3'd1:    e = m_snap_sec[63:32];
                    3'd2:    e = m_snap_ns;
                    3'd3:    e = m_step;
                    default: e = '0;
                endcase
                exp_q.push_back(e);
                tag_q.push_back(cur_tag);
            end
            if (wr_en && addr == 3'd7) begin
                m_sec = m_ssec;
                m_ns  = (m_sns >= BILLION) ? BILLION - 1 : m_sns;
            end else begin
                t = longint'(m_ns) + longint'(m_step);
                if (t >= longint'(BILLION)) begin
                    t = t - longint'(BILLION);
                    m_sec = m_sec + 1;
                end
                m_ns = 32'(t);
            end
            if (wr_en) begin
                case (addr)
                    3'd3: m_step = (wdata > BILLION - 1) ? BILLION - 1 : wdata;
                    3'd4: m_ssec[31:0]  = wdata;
                    3'd5: m_ssec[63:32] = wdata;
                    3'd6: m_sns = wdata;
                    default: ;
                endcase
            end
        end
    end

    // Monitor: compare each returned word with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        cur_tag = tag; rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_time(input string tag);
        rd(3'd0, tag);
        rd(3'd1, tag);
        rd(3'd2, tag);
    endtask

    task automatic load(input logic [63:0] s, input logic [31:0] n);
        wr(3'd4, s[31:0]);
        wr(3'd5, s[63:32]);
        wr(3'd6, n);
        wr(3'd7, 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_vec++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset, then zero time and default step
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 32'd0);
        check("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        rst = 1'b0;
        cur_tag = "R1"; rd_en = 1'b1; addr = 3'd0;
        @(negedge clk);
        rd_en = 1'b0;
        rd(3'd1, "R1");
        rd(3'd2, "R1");
        rd(3'd3, "R1");

        // R2: accumulation with the default step and with step 7
        idle(5);
        rd_time("R2 step10");
        wr(3'd3, 32'd7);
        idle(4);
        rd_time("R2 step7");

        // R9: step read back, limit, unmapped reads
        rd(3'd3, "R9 step");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, "R9 step limit");
        for (int a = 4; a < 8; a++) rd(3'(a), "R9 write-only read");

        // R6: staging writes with time frozen have no effect
        wr(3'd3, 32'd0);
        load(64'd0, 32'd0);
        wr(3'd4, 32'hDEAD_BEEF);
        wr(3'd5, 32'h1234_5678);
        wr(3'd6, 32'd55);
        idle(3);
        rd_time("R6 staged only");

        // R7: commit applies the held value; counting resumes
        wr(3'd7, 32'd0);
        rd_time("R7 committed");
        wr(3'd3, 32'd1);
        idle(6);
        rd_time("R7 counting");

        // R3: exact boundary with step 1, then frequent carries
        load(64'd5, BILLION - 3);
        for (int i = 0; i < 4; i++) rd_time("R3 boundary");
        wr(3'd3, 32'd333_333_333);
        for (int i = 0; i < 4; i++) rd_time("R3 carries");

        // R4: carry across the 32-bit seconds word
        wr(3'd3, 32'd10);
        load(64'h0000_0000_FFFF_FFFF, BILLION - 30);
        idle(2);
        rd_time("R4 wide carry");

        // R8: out-of-range nanoseconds are limited
        wr(3'd3, 32'd0);
        load(64'd9, 32'd1_500_000_000);
        rd_time("R8 clamp");
        load(64'd9, 32'hFFFF_FFFF);
        rd_time("R8 clamp max");
        wr(3'd3, 32'd1);
        idle(2);
        rd_time("R8 after clamp");

        // R5: snapshot survives elapsed time
        wr(3'd3, 32'd400_000_000);
        rd(3'd0, "R5 snapshot");
        idle(20);
        rd(3'd1, "R5 snapshot");
        rd(3'd2, "R5 snapshot");
        rd(3'd0, "R5 fresh");
        rd(3'd2, "R5 fresh");

        // R10: back-to-back reads
        @(negedge clk);
        cur_tag = "R10 burst"; rd_en = 1'b1; addr = 3'd0;
        @(negedge clk); addr = 3'd1;
        @(negedge clk); addr = 3'd2;
        @(negedge clk); addr = 3'd3;
        @(negedge clk); rd_en = 1'b0;
        idle(3);
        if (exp_q.size() != 0) check("R10 missing rd_valid", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule